// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This engine serves the transmit side of a network controller. Software places 32-byte descriptors in a ring in memory and hands each one over by setting its ownership bit. A single-cycle poll strobe starts a walk. The engine reads the descriptor at its current pointer and checks the segment length. It then asks the frame assembler to copy the segment, using an address/length request handshake. When the segment closes a frame, the engine reports the frame and its total length. It then writes the control word back with ownership cleared and moves to the next descriptor. The next descriptor is the following 32-byte slot, or the ring base when the descriptor carries the wrap mark.

A walk ends silently in three cases: the engine finds a descriptor it does not own, the segment sizes are malformed, or the accumulated frame would not fit the frame buffer. In all three cases the descriptor is neither copied nor written back, so the pointer stays on it. A poll that arrives during a walk is remembered, and exactly one more walk follows. Every memory access is a single 32-bit word, presented with valid and held until ready; read data is taken in the cycle in which ready is high.

The controller has eight states:
- `ST_IDLE` waits for a start: a poll, or a remembered poll.
- `ST_RD_CTL` reads descriptor word 0. It goes to `ST_RD_SIZE` when the descriptor is owned, and back to `ST_IDLE` when it is not.
- `ST_RD_SIZE` reads word 1 and goes to `ST_RD_BUF`.
- `ST_RD_BUF` reads word 2 and goes to `ST_CHECK`.
- `ST_CHECK` goes to `ST_COPY` when the sizes are accepted, and to `ST_IDLE` when they are not.
- `ST_COPY` holds the copy request and goes to `ST_WRBACK` on copy ready.
- `ST_WRBACK` writes word 0 and goes to `ST_ADVANCE` on memory ready.
- `ST_ADVANCE` steps or wraps the pointer and returns to `ST_RD_CTL`.

Top module: `txring_walker`

## Requirements
- R1: After reset the engine is idle: `busy_o`=0, no memory or copy request, pointer 0, both status flags 0. A poll starts a walk that reads word 0 at the current pointer. If bit 31 (ownership) of that word is 0, the walk ends with no copy, no write and an unchanged pointer.
- R2: At most one memory access or copy request is outstanding at a time. `mem_valid_o` stays high, with the same address, direction and data, until `mem_ready_i` is high.
- R3: The segment length is bits 11:0 of word 1; bits 15:12 are ignored. Bits 27:16 of word 1 form the second-buffer length, and bits 31:28 are ignored. If the segment length is above 2048, or the second-buffer length is not zero, the walk ends with no copy and no write-back. A length of exactly 2048 is accepted.
- R4: If the accumulated frame length plus the segment length is 8192 or more, the walk ends with no copy and no write-back. The accumulated length restarts at 0 at the start of every walk.
- R5: For an accepted segment, the copy request presents address = word 2 and length = segment length. The request is held until `copy_ready_i`.
- R6: When bit 29 (last segment) of word 0 is set, `frame_done_o` pulses for one cycle with `frame_len_o` = the summed lengths of the frame's segments. The accumulated length then returns to 0. `stat_ti_o` and `stat_nis_o` are set and stay set until `stat_clr_i`; a set in the same cycle as a clear wins.
- R7: Write-back stores word 0 at the current pointer with bit 31 cleared and every other bit unchanged. It happens only after the copy has been accepted.
- R8: After write-back the pointer reloads from the ring base if bit 21 (wrap) of word 0 is set, and otherwise adds 32. `base_wr_i` loads both the base and the pointer.
- R9: A poll during a walk is latched and causes exactly one more walk after the current one ends; several polls in one walk still cause only one more.
- R10: `busy_o` is high in every state except idle. No request is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Poll strobe, starts or re-arms a walk |
| base_wr_i | input | 1 | Load ring base and current pointer |
| base_addr_i | input | ADDR_W | Ring base address |
| mem_valid_o | output | 1 | Memory word access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| copy_valid_o | output | 1 | Segment copy request |
| copy_addr_o | output | ADDR_W | Segment buffer address |
| copy_len_o | output | SIZE_W | Segment length in bytes |
| copy_ready_i | input | 1 | Copy request accepted |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| frame_len_o | output | LEN_W | Total frame length |
| stat_clr_i | input | 1 | Clear both status flags |
| stat_ti_o | output | 1 | Transmit-done status flag |
| stat_nis_o | output | 1 | Normal-summary status flag |
| busy_o | output | 1 | Walk in progress |
| cur_ptr_o | output | ADDR_W | Current descriptor pointer |

## Verification
The assertions check the following on every cycle:
- Memory and copy requests stay stable while they wait.
- The two kinds of request never overlap, and the idle state issues neither.
- No write-back carries the ownership bit.
- Every frame pulse comes with both status flags set.
- Each pointer change is either a 32-byte step or a reload from the base.

Only the bench scenarios can show:
- which descriptor ends a walk, and that the stopping descriptor is left untouched in memory;
- the exact lengths summed across segments, including the 8191/8192 boundary and the restart of the sum on a new walk;
- that the first-buffer size limit lies at 2048;
- that a poll during a walk produces exactly one extra read of the stopping descriptor.

// File: rtl/txw_pkg.sv
package txw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_RD_SIZE,
        ST_RD_BUF,
        ST_CHECK,
        ST_COPY,
        ST_WRBACK,
        ST_ADVANCE
    } walk_state_e;

    // Control-word bit positions that software and the engine share
    localparam int OWN_BIT  = 31;
    localparam int LAST_BIT = 29;
    localparam int WRAP_BIT = 21;

    // Descriptor geometry
    localparam int DESC_BYTES  = 32;
    localparam int OFS_CTL     = 0;
    localparam int OFS_SIZE    = 4;
    localparam int OFS_BUF     = 8;
    localparam int SIZE2_LSB   = 16;

endpackage

// File: rtl/txw_desc_check.sv
module txw_desc_check #(
    parameter int SIZE_W    = 12,
    parameter int MAX_SEG   = 2048,
    parameter int FRAME_CAP = 8192,
    parameter int LEN_W     = 13
) (
    input  logic [31:0]       size_word,
    input  logic [LEN_W-1:0]  acc_len,
    output logic [SIZE_W-1:0] seg_len,
    output logic [LEN_W-1:0]  total_len,
    output logic              accept
);
    import txw_pkg::*;

    localparam logic [SIZE_W:0] MAX_SEG_V   = MAX_SEG[SIZE_W:0];
    localparam logic [LEN_W:0]  FRAME_CAP_V = FRAME_CAP[LEN_W:0];
    localparam int              PAD_W       = LEN_W + 1 - SIZE_W;

    logic [SIZE_W-1:0] second_len;
    logic [LEN_W:0]    sum;
    logic              seg_ok;
    logic              second_ok;
    logic              fits;

    always_comb begin
        seg_len    = size_word[SIZE_W-1:0];
        second_len = size_word[SIZE2_LSB +: SIZE_W];
        sum        = {1'b0, acc_len} + {{PAD_W{1'b0}}, seg_len};
        seg_ok     = ({1'b0, seg_len} <= MAX_SEG_V);
        second_ok  = (second_len == '0);
        fits       = (sum < FRAME_CAP_V);
        accept     = seg_ok && second_ok && fits;
        total_len  = sum[LEN_W-1:0];
    end

endmodule

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              step,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] base
);
    import txw_pkg::*;

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            base <= '0;
        end else if (load_base) begin
            ptr  <= base_in;
            base <= base_in;
        end else if (step) begin
            ptr  <= wrap ? base : ptr + STRIDE;
        end
    end

endmodule

// File: rtl/txw_poll_latch.sv
module txw_poll_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic poll,
    input  logic start,
    output logic pending
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (start) begin
            pending <= 1'b0;
        end else if (poll) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/txw_status.sv
module txw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic ti,
    output logic nis
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ti  <= 1'b0;
            nis <= 1'b0;
        end else if (set) begin
            ti  <= 1'b1;
            nis <= 1'b1;
        end else if (clr) begin
            ti  <= 1'b0;
            nis <= 1'b0;
        end
    end

endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 12,
    parameter int MAX_SEG   = 2048,
    parameter int FRAME_CAP = 8192,
    parameter int LEN_W     = $clog2(FRAME_CAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              mem_valid_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              copy_valid_o,
    output logic [ADDR_W-1:0] copy_addr_o,
    output logic [SIZE_W-1:0] copy_len_o,
    input  logic              copy_ready_i,
    output logic              frame_done_o,
    output logic [LEN_W-1:0]  frame_len_o,
    input  logic              stat_clr_i,
    output logic              stat_ti_o,
    output logic              stat_nis_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] cur_ptr_o
);
    import txw_pkg::*;

    walk_state_e state_q, state_d;

    logic [31:0]       ctl_q;
    logic [31:0]       size_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] seg_len;
    logic [LEN_W-1:0]  total_len;
    logic              accept;
    logic              pending;
    logic              start;
    logic              mem_done;
    logic              copy_done;
    logic              seg_last;
    logic              frame_fire;

    assign start      = (state_q == ST_IDLE) && (poll_i || pending);
    assign mem_done   = mem_valid_o && mem_ready_i;
    assign copy_done  = copy_valid_o && copy_ready_i;
    assign seg_last   = ctl_q[LAST_BIT];
    assign frame_fire = copy_done && seg_last;

    txw_desc_check #(
        .SIZE_W   (SIZE_W),
        .MAX_SEG  (MAX_SEG),
        .FRAME_CAP(FRAME_CAP),
        .LEN_W    (LEN_W)
    ) u_check (
        .size_word(size_q),
        .acc_len  (acc_q),
        .seg_len  (seg_len),
        .total_len(total_len),
        .accept   (accept)
    );

    txw_ring_ptr #(
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_base(base_wr_i),
        .base_in  (base_addr_i),
        .step     (state_q == ST_ADVANCE),
        .wrap     (ctl_q[WRAP_BIT]),
        .ptr      (cur_ptr_o),
        .base     (base_q)
    );

    txw_poll_latch u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .poll   (poll_i),
        .start  (start),
        .pending(pending)
    );

    txw_status u_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (frame_fire),
        .clr  (stat_clr_i),
        .ti   (stat_ti_o),
        .nis  (stat_nis_o)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RD_CTL;
            ST_RD_CTL:  if (mem_done) state_d = mem_rdata_i[OWN_BIT] ? ST_RD_SIZE : ST_IDLE;
            ST_RD_SIZE: if (mem_done) state_d = ST_RD_BUF;
            ST_RD_BUF:  if (mem_done) state_d = ST_CHECK;
            ST_CHECK:   state_d = accept ? ST_COPY : ST_IDLE;
            ST_COPY:    if (copy_done) state_d = ST_WRBACK;
            ST_WRBACK:  if (mem_done) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = ST_RD_CTL;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        mem_valid_o  = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = cur_ptr_o;
        mem_wdata_o  = ctl_q;
        mem_wdata_o[OWN_BIT] = 1'b0;
        copy_valid_o = 1'b0;
        busy_o       = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_RD_CTL: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = cur_ptr_o + ADDR_W'(OFS_CTL);
            end
            ST_RD_SIZE: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = cur_ptr_o + ADDR_W'(OFS_SIZE);
            end
            ST_RD_BUF: begin
                mem_valid_o = 1'b1;
                mem_addr_o  = cur_ptr_o + ADDR_W'(OFS_BUF);
            end
            ST_CHECK:   ;
            ST_COPY:    copy_valid_o = 1'b1;
            ST_WRBACK: begin
                mem_valid_o = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = cur_ptr_o + ADDR_W'(OFS_CTL);
            end
            ST_ADVANCE: ;
            default:    busy_o = 1'b0;
        endcase
        copy_addr_o = buf_q;
        copy_len_o  = seg_len;
    end

    // Descriptor capture, frame accumulation and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            size_q       <= '0;
            buf_q        <= '0;
            acc_q        <= '0;
            frame_done_o <= 1'b0;
            frame_len_o  <= '0;
        end else begin
            frame_done_o <= 1'b0;
            if (start) acc_q <= '0;
            if (mem_done && state_q == ST_RD_CTL)  ctl_q  <= mem_rdata_i;
            if (mem_done && state_q == ST_RD_SIZE) size_q <= mem_rdata_i;
            if (mem_done && state_q == ST_RD_BUF)  buf_q  <= mem_rdata_i[ADDR_W-1:0];
            if (copy_done) begin
                if (seg_last) begin
                    acc_q        <= '0;
                    frame_done_o <= 1'b1;
                    frame_len_o  <= total_len;
                end else begin
                    acc_q <= total_len;
                end
            end
        end
    end

endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_wr_i,
    input logic              mem_valid_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [31:0]       mem_wdata_o,
    input logic              mem_ready_i,
    input logic              copy_valid_o,
    input logic [ADDR_W-1:0] copy_addr_o,
    input logic              copy_ready_i,
    input logic              frame_done_o,
    input logic              stat_ti_o,
    input logic              stat_nis_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] cur_ptr_o,
    input logic [ADDR_W-1:0] base_q
);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R2
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid_o && copy_valid_o));

    // R5
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid_o && !copy_ready_i) |=> (copy_valid_o && $stable(copy_addr_o)));

    // R7
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_we_o) |-> !mem_wdata_o[31]);

    // R6
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (stat_ti_o && stat_nis_o));

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_ptr_o) && !$past(base_wr_i)) |->
            (cur_ptr_o == $past(cur_ptr_o) + 32'd32 || cur_ptr_o == $past(base_q)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_valid_o && !copy_valid_o));

endmodule

bind txring_walker txw_walker_chk #(.ADDR_W(ADDR_W)) u_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_wr_i   (base_wr_i),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .copy_valid_o(copy_valid_o),
    .copy_addr_o (copy_addr_o),
    .copy_ready_i(copy_ready_i),
    .frame_done_o(frame_done_o),
    .stat_ti_o   (stat_ti_o),
    .stat_nis_o  (stat_nis_o),
    .busy_o      (busy_o),
    .cur_ptr_o   (cur_ptr_o),
    .base_q      (base_q)
);

// File: tb/txring_walker_tb_top.sv
module txring_walker_tb_top;

    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] LAST = 32'h2000_0000;
    localparam logic [31:0] WRAP = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_i = 1'b0;
    logic        base_wr_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic        mem_valid_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        copy_valid_o;
    logic [31:0] copy_addr_o;
    logic [11:0] copy_len_o;
    logic        copy_ready_i = 1'b0;
    logic        frame_done_o;
    logic [12:0] frame_len_o;
    logic        stat_clr_i = 1'b0;
    logic        stat_ti_o, stat_nis_o, busy_o;
    logic [31:0] cur_ptr_o;

    always #5 clk = ~clk;

    txring_walker dut_i (
        .clk(clk), .rst_n(rst_n), .poll_i(poll_i),
        .base_wr_i(base_wr_i), .base_addr_i(base_addr_i),
        .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .copy_valid_o(copy_valid_o), .copy_addr_o(copy_addr_o), .copy_len_o(copy_len_o),
        .copy_ready_i(copy_ready_i), .frame_done_o(frame_done_o), .frame_len_o(frame_len_o),
        .stat_clr_i(stat_clr_i), .stat_ti_o(stat_ti_o), .stat_nis_o(stat_nis_o),
        .busy_o(busy_o), .cur_ptr_o(cur_ptr_o)
    );

    logic [31:0] mem [0:255];
    int          n_checks = 0;
    int          n_errors = 0;
    int          n_copies = 0;
    int          n_frames = 0;
    int          n_writes = 0;
    int          watch_reads = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    logic [31:0] last_copy_addr = '0;
    logic [11:0] last_copy_len = '0;
    logic [12:0] last_frame_len = '0;

    // Memory and copy responders: one-cycle-late ready, data with ready
    always @(negedge clk) begin
        if (mem_ready_i) begin
            mem_ready_i <= 1'b0;
        end else if (mem_valid_o) begin
            mem_ready_i <= 1'b1;
            if (mem_we_o) begin
                mem[mem_addr_o[9:2]] <= mem_wdata_o;
                n_writes <= n_writes + 1;
            end else begin
                mem_rdata_i <= mem[mem_addr_o[9:2]];
                if (mem_addr_o == watch_addr) watch_reads <= watch_reads + 1;
            end
        end
        if (copy_ready_i) begin
            copy_ready_i <= 1'b0;
        end else if (copy_valid_o) begin
            copy_ready_i   <= 1'b1;
            n_copies       <= n_copies + 1;
            last_copy_addr <= copy_addr_o;
            last_copy_len  <= copy_len_o;
        end
        if (frame_done_o) begin
            n_frames       <= n_frames + 1;
            last_frame_len <= frame_len_o;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] ctl,
                            input logic [31:0] sz, input logic [31:0] bufa);
        mem[a[9:2]]     = ctl;
        mem[a[9:2] + 1] = sz;
        mem[a[9:2] + 2] = bufa;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (busy_o) quiet = 0;
            else        quiet++;
        end
    endtask

    task automatic do_poll();
        @(negedge clk) poll_i = 1'b1;
        @(negedge clk) poll_i = 1'b0;
        wait_idle();
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk) begin base_wr_i = 1'b1; base_addr_i = b; end
        @(negedge clk) base_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
        check("R10", "mem valid idle", {31'd0, mem_valid_o}, 32'd0);
        check("R10", "copy valid idle", {31'd0, copy_valid_o}, 32'd0);
        check("R1", "ptr after reset", cur_ptr_o, 32'd0);
        check("R1", "ti after reset", {31'd0, stat_ti_o}, 32'd0);
    endtask

    task automatic t_single();
        put_desc(32'h00, OWN | LAST | 32'h123, 32'd100, 32'h1000);
        do_poll();
        check("R5", "copies single", n_copies, 1);
        check("R5", "copy addr", last_copy_addr, 32'h1000);
        check("R5", "copy len", {20'd0, last_copy_len}, 32'd100);
        check("R6", "frames single", n_frames, 1);
        check("R6", "frame len", {19'd0, last_frame_len}, 32'd100);
        check("R7", "writeback word0", mem[0], LAST | 32'h123);
        check("R8", "ptr step", cur_ptr_o, 32'h20);
        check("R6", "ti set", {31'd0, stat_ti_o}, 32'd1);
        check("R6", "nis set", {31'd0, stat_nis_o}, 32'd1);
        @(negedge clk) stat_clr_i = 1'b1;
        @(negedge clk) stat_clr_i = 1'b0;
        check("R6", "ti cleared", {31'd0, stat_ti_o}, 32'd0);
    endtask

    task automatic t_multi();
        put_desc(32'h20, OWN, 32'd200, 32'h2000);
        put_desc(32'h40, OWN | LAST, 32'd300, 32'h3000);
        do_poll();
        check("R5", "copies multi", n_copies, 3);
        check("R6", "frames multi", n_frames, 2);
        check("R6", "multi frame len", {19'd0, last_frame_len}, 32'd500);
        check("R7", "first seg wb", mem[8], 32'd0);
        check("R8", "ptr multi", cur_ptr_o, 32'h60);
    endtask

    task automatic t_unowned();
        int w0 = n_writes;
        do_poll();
        check("R1", "unowned no copy", n_copies, 3);
        check("R1", "unowned no write", n_writes, w0);
        check("R1", "unowned ptr", cur_ptr_o, 32'h60);
    endtask

    task automatic t_upper_bits();
        put_desc(32'h60, OWN | LAST, 32'hF000_F064, 32'h4000);
        do_poll();
        check("R3", "upper bits copy len", {20'd0, last_copy_len}, 32'd100);
        check("R3", "upper bits ptr", cur_ptr_o, 32'h80);
    endtask

    task automatic t_bad_buf1();
        int c0 = n_copies;
        put_desc(32'h80, OWN | LAST, 32'd2049, 32'h5000);
        do_poll();
        check("R3", "2049 no copy", n_copies, c0);
        check("R3", "2049 not written", mem[32], OWN | LAST);
        check("R3", "2049 ptr", cur_ptr_o, 32'h80);
        mem[33] = 32'd2048;
        do_poll();
        check("R3", "2048 accepted len", {19'd0, last_frame_len}, 32'd2048);
        check("R3", "2048 ptr", cur_ptr_o, 32'hA0);
    endtask

    task automatic t_bad_buf2();
        int c0 = n_copies;
        put_desc(32'hA0, OWN | LAST, 32'h0001_0064, 32'h6000);
        do_poll();
        check("R3", "buf2 no copy", n_copies, c0);
        check("R3", "buf2 ptr", cur_ptr_o, 32'hA0);
        check("R3", "buf2 not written", mem[40], OWN | LAST);
    endtask

    task automatic t_wrap();
        set_base(32'h100);
        check("R8", "base load ptr", cur_ptr_o, 32'h100);
        put_desc(32'h100, OWN | LAST | WRAP, 32'd64, 32'h7000);
        do_poll();
        check("R8", "wrap ptr", cur_ptr_o, 32'h100);
        check("R7", "wrap wb", mem[64], LAST | WRAP);
        check("R6", "wrap frame len", {19'd0, last_frame_len}, 32'd64);
    endtask

    task automatic t_overflow();
        int f0;
        set_base(32'h200);
        for (int i = 0; i < 3; i++) put_desc(32'h200 + 32'(i * 32), OWN, 32'd2048, 32'h8000);
        put_desc(32'h260, OWN | LAST, 32'd2048, 32'h9000);
        f0 = n_frames;
        do_poll();
        check("R4", "overflow no frame", n_frames, f0);
        check("R4", "overflow ptr", cur_ptr_o, 32'h260);
        check("R4", "overflow not written", mem[152], OWN | LAST);
        do_poll();
        check("R4", "acc restarts", {19'd0, last_frame_len}, 32'd2048);
        check("R4", "restart ptr", cur_ptr_o, 32'h280);
        set_base(32'h300);
        for (int i = 0; i < 3; i++) put_desc(32'h300 + 32'(i * 32), OWN, 32'd2048, 32'hA000);
        put_desc(32'h360, OWN | LAST, 32'd2047, 32'hB000);
        do_poll();
        check("R4", "8191 frame len", {19'd0, last_frame_len}, 32'd8191);
        check("R4", "8191 ptr", cur_ptr_o, 32'h380);
    endtask

    task automatic t_pending();
        watch_addr = 32'h380;
        watch_reads = 0;
        @(negedge clk) poll_i = 1'b1;
        @(negedge clk) poll_i = 1'b1;
        @(negedge clk) poll_i = 1'b0;
        wait_idle();
        check("R9", "latched poll reads", watch_reads, 2);
        check("R10", "idle at end", {31'd0, busy_o}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_unowned();
        t_upper_bits();
        t_bad_buf1();
        t_bad_buf2();
        t_wrap();
        t_overflow();
        t_pending();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule